// File: doc/BRIEF.md
# Lock Status Seven-Segment Display Controller

This block drives a four-digit, common-anode seven-segment display for a digital lock. It takes a 2-bit lock status code and the 16-bit passcode being typed, and scans the digits one at a time from a free-running refresh counter. Segment lines and digit enables are active low.

In three of the four status codes every digit shows the same status letter: C when the lock is closed, O when it is open, and S when a new code has been stored. In the code-entry status the four passcode nibbles are shown as hexadecimal characters and follow the user's typing. The status and passcode are copied into a display snapshot once per full scan frame, so a single frame never mixes two inputs. After reset the segments stay dark until the first snapshot has been taken.

Top module: `safe_status_display`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become `digit_en_n_o` = 4'b0111 (only the leftmost digit, bit 3, enabled), `seg_n_o` = 7'h7F (all segments dark) and `dp_n_o` = 1.
- R2: On the first clock edge after reset is released the segments stay all dark. The display snapshot is taken on that edge, and glyphs appear from the second edge on.
- R3: Exactly one digit enable is low at any time. The enabled digit moves from the leftmost (bit 3) to the rightmost (bit 0) and then wraps back to bit 3. The segment pattern and the enable are registered together, so both change on the same edge.
- R4: Each digit stays enabled for exactly `DWELL_CYCLES` consecutive clock cycles.
- R5: Status 2'b00 (closed) shows C on every digit: `seg_n_o` = 7'h46, with segment order bit0=a through bit6=g.
- R6: Status 2'b01 (open) shows O on every digit, with the same segments as the numeral zero: `seg_n_o` = 7'h40.
- R7: Status 2'b11 (new code stored) shows S on every digit, with the same segments as the numeral five: `seg_n_o` = 7'h12.
- R8: Status 2'b10 (code entry) shows passcode bits [15:12] on the leftmost digit, [11:8] on the next, [7:4] on the third and [3:0] on the rightmost.
- R9: In code entry, nibble values 0..F give these active-low patterns: 40,79,24,30,19,12,02,78,00,10,08,03,46,21,06,0E (hex). The letters A to F are drawn as A, b, C, d, E, F.
- R10: The status and passcode are sampled only when the scan wraps from the rightmost digit back to the leftmost. An input change in the middle of a frame leaves the rest of that frame unchanged and shows from the first digit of the next frame.
- R11: The decimal point output `dp_n_o` is always 1 (off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_status_i | input | 2 | Lock status code (00 closed, 01 open, 10 code entry, 11 code stored) |
| passcode_i | input | 16 | Passcode as four nibbles, most significant nibble leftmost |
| seg_n_o | output | 7 | Active-low segments, bit0=a through bit6=g |
| dp_n_o | output | 1 | Active-low decimal point, held off |
| digit_en_n_o | output | 4 | Active-low digit enables, bit 3 leftmost |

## Verification
Some properties are checked on every cycle: a single low digit enable, a digit that advances only when its dwell count is used up, a snapshot that holds between frame wraps, and dark segments on the first edge after reset. Other behaviour needs the bench's scenarios to show it. These are the glyph chosen for each status code, the placement of each nibble, the full hex character set, the left-to-right scan order, and a mid-frame input change that appears only from the next frame's first digit.

// File: rtl/ssd_pkg.sv
// Shared types and glyph encodings for the lock status display.
// Assumes segment vectors are ordered bit0=a .. bit6=g and active high
// inside the block; inversion to active low happens at the outputs.
package ssd_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;

    typedef enum logic [1:0] {
        ST_CLOSED = 2'b00,
        ST_OPENED = 2'b01,
        ST_ENTRY  = 2'b10,
        ST_STORED = 2'b11
    } lock_status_e;

    typedef logic [SEG_W-1:0] seg_t;

    localparam seg_t GLYPH_LET_C = 7'h39;
    localparam seg_t GLYPH_LET_O = 7'h3F;
    localparam seg_t GLYPH_LET_S = 7'h6D;
    localparam seg_t GLYPH_DARK  = 7'h00;

    // Map one nibble to its hex character, active high.
    function automatic seg_t hex_glyph(input logic [NIB_W-1:0] nib);
        seg_t g;
        case (nib)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/ssd_scan_timer.sv
// Refresh counter and digit scan index.
// Counts DWELL_CYCLES clocks per digit, then steps the index from 0
// (leftmost) to DIGITS-1 (rightmost) and wraps. frame_wrap_o is high in
// the cycle whose edge returns the scan to digit 0.
// Assumes DWELL_CYCLES >= 2 and DIGITS >= 2.
module ssd_scan_timer #(
    parameter int DWELL_CYCLES = 100000,
    parameter int DIGITS       = 4,
    localparam int CNT_W       = $clog2(DWELL_CYCLES),
    localparam int IDX_W       = $clog2(DIGITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] idx_o,
    output logic             frame_wrap_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             dwell_done;

    assign dwell_done   = (cnt_q == CNT_LAST);
    assign frame_wrap_o = dwell_done && (idx_q == IDX_LAST);
    assign idx_o        = idx_q;

    // Dwell counter: restarts at zero after each digit period.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (dwell_done) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    // Digit index: steps once per dwell period and wraps after the last digit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       idx_q <= '0;
        else if (dwell_done) begin
            if (idx_q == IDX_LAST)        idx_q <= '0;
            else                          idx_q <= idx_q + 1'b1;
        end
    end

    // R4: the digit index moves only when a full dwell period has elapsed.
    p_dwell_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> ($past(cnt_q) == CNT_LAST));

    // R4: the dwell counter never runs past its last value.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_LAST));

endmodule

// File: rtl/ssd_frame_latch.sv
// Display snapshot of status and passcode.
// Loads on the first clock after reset and on every frame wrap; holds
// otherwise so one frame always shows one consistent input.
module ssd_frame_latch
    import ssd_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int PASS_W = DIGITS * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_wrap_i,
    input  logic [1:0]        status_i,
    input  logic [PASS_W-1:0] pass_i,
    output lock_status_e      status_o,
    output logic [PASS_W-1:0] pass_o,
    output logic              valid_o
);

    lock_status_e      status_q;
    logic [PASS_W-1:0] pass_q;
    logic              valid_q;
    logic              load;

    assign load     = !valid_q || frame_wrap_i;
    assign status_o = status_q;
    assign pass_o   = pass_q;
    assign valid_o  = valid_q;

    // Snapshot registers: capture inputs on a load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_CLOSED;
            pass_q   <= '0;
            valid_q  <= 1'b0;
        end else if (load) begin
            status_q <= lock_status_e'(status_i);
            pass_q   <= pass_i;
            valid_q  <= 1'b1;
        end
    end

    // R10: between frame wraps the snapshot does not move.
    p_snapshot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap_i && valid_q |=> $stable(pass_q) && $stable(status_q));

    // R2: once a load has happened the snapshot is marked valid.
    p_valid_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> valid_q);

endmodule

// File: rtl/ssd_glyph_sel.sv
// Glyph selection for the digit being scanned.
// Splits the passcode into per-digit nibbles (digit 0 = most significant)
// and picks either the status letter or the nibble's hex character.
// Output is active high and purely combinational.
module ssd_glyph_sel
    import ssd_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int PASS_W = DIGITS * NIB_W,
    localparam int IDX_W  = $clog2(DIGITS)
) (
    input  lock_status_e      status_i,
    input  logic [PASS_W-1:0] pass_i,
    input  logic [IDX_W-1:0]  idx_i,
    output seg_t              seg_o
);

    logic [NIB_W-1:0] nib_arr [DIGITS];
    logic [NIB_W-1:0] nib_sel;

    // Nibble split: digit d takes the d-th nibble counted from the top.
    for (genvar d = 0; d < DIGITS; d++) begin : g_nib
        assign nib_arr[d] = pass_i[(DIGITS-1-d)*NIB_W +: NIB_W];
    end

    // Nibble mux for the scanned digit.
    always_comb begin
        nib_sel = '0;
        for (int d = 0; d < DIGITS; d++) begin
            if (idx_i == IDX_W'(d)) nib_sel = nib_arr[d];
        end
    end

    // Status-dependent glyph choice.
    always_comb begin
        unique case (status_i)
            ST_CLOSED: seg_o = GLYPH_LET_C;
            ST_OPENED: seg_o = GLYPH_LET_O;
            ST_STORED: seg_o = GLYPH_LET_S;
            default:   seg_o = hex_glyph(nib_sel);
        endcase
    end

endmodule

// File: rtl/safe_status_display.sv
// Lock status seven-segment display controller (top).
// Time-multiplexes a DIGITS-wide common-anode display: one digit enable
// low at a time, leftmost digit on the highest enable bit. Segment and
// enable outputs are registered together. Segments stay dark until the
// first snapshot of status and passcode has been taken.
module safe_status_display
    import ssd_pkg::*;
#(
    parameter int DWELL_CYCLES = 100000,
    parameter int DIGITS       = 4,
    localparam int PASS_W      = DIGITS * NIB_W,
    localparam int IDX_W       = $clog2(DIGITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lock_status_i,
    input  logic [PASS_W-1:0] passcode_i,
    output logic [SEG_W-1:0]  seg_n_o,
    output logic              dp_n_o,
    output logic [DIGITS-1:0] digit_en_n_o
);

    localparam logic [DIGITS-1:0] EN_LEFT_N = ~(DIGITS'(1) << (DIGITS - 1));

    logic [IDX_W-1:0]  scan_idx;
    logic              frame_wrap;
    lock_status_e      snap_status;
    logic [PASS_W-1:0] snap_pass;
    logic              snap_valid;
    seg_t              glyph;
    logic [DIGITS-1:0] en_n_next;

    ssd_scan_timer #(
        .DWELL_CYCLES (DWELL_CYCLES),
        .DIGITS       (DIGITS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx_o        (scan_idx),
        .frame_wrap_o (frame_wrap)
    );

    ssd_frame_latch #(
        .DIGITS       (DIGITS)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_wrap_i (frame_wrap),
        .status_i     (lock_status_i),
        .pass_i       (passcode_i),
        .status_o     (snap_status),
        .pass_o       (snap_pass),
        .valid_o      (snap_valid)
    );

    ssd_glyph_sel #(
        .DIGITS       (DIGITS)
    ) u_glyph (
        .status_i     (snap_status),
        .pass_i       (snap_pass),
        .idx_i        (scan_idx),
        .seg_o        (glyph)
    );

    // Enable decode: scan index 0 maps to the highest enable bit.
    always_comb begin
        en_n_next = '1;
        for (int d = 0; d < DIGITS; d++) begin
            if (scan_idx == IDX_W'(d)) en_n_next[DIGITS-1-d] = 1'b0;
        end
    end

    // Output registers: segments and enable update on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_n_o      <= '1;
            digit_en_n_o <= EN_LEFT_N;
        end else begin
            seg_n_o      <= snap_valid ? ~glyph : ~GLYPH_DARK;
            digit_en_n_o <= en_n_next;
        end
    end

    // Decimal point is never lit.
    assign dp_n_o = 1'b1;

    // R3: exactly one digit is enabled on every cycle.
    p_one_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~digit_en_n_o) == 1);

    // R2: on the first edge after reset the segments are still dark.
    p_dark_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (seg_n_o == '1));

endmodule

// File: tb/safe_status_display_tb.sv
// Scoreboard bench: a driver pushes the expected digit sequence for each
// frame, a monitor pops one entry per output change and compares.
module safe_status_display_tb_top;

    localparam int DW = 8;

    logic        clk;
    logic        rst_n;
    logic [1:0]  lock_status;
    logic [15:0] passcode;
    logic [6:0]  seg_n;
    logic        dp_n;
    logic [3:0]  en_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [10:0] exp_q [$];
    string       tag_q [$];

    safe_status_display #(.DWELL_CYCLES(DW), .DIGITS(4)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_status_i (lock_status),
        .passcode_i    (passcode),
        .seg_n_o       (seg_n),
        .dp_n_o        (dp_n),
        .digit_en_n_o  (en_n)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected active-low pattern from the requirement tables (R5..R9).
    function automatic logic [6:0] exp_seg(input logic [1:0] st, input logic [3:0] nib);
        logic [6:0] hi;
        if (st == 2'b00)      hi = 7'h39;
        else if (st == 2'b01) hi = 7'h3F;
        else if (st == 2'b11) hi = 7'h6D;
        else begin
            case (nib)
                4'h0: hi = 7'h3F; 4'h1: hi = 7'h06; 4'h2: hi = 7'h5B; 4'h3: hi = 7'h4F;
                4'h4: hi = 7'h66; 4'h5: hi = 7'h6D; 4'h6: hi = 7'h7D; 4'h7: hi = 7'h07;
                4'h8: hi = 7'h7F; 4'h9: hi = 7'h6F; 4'hA: hi = 7'h77; 4'hB: hi = 7'h7C;
                4'hC: hi = 7'h39; 4'hD: hi = 7'h5E; 4'hE: hi = 7'h79; default: hi = 7'h71;
            endcase
        end
        return ~hi;
    endfunction

    task automatic push_frame(input logic [1:0] st, input logic [15:0] pw, input string tag);
        for (int d = 0; d < 4; d++) begin
            logic [3:0] en_e;
            logic [3:0] nib;
            en_e = ~(4'b1000 >> d);
            nib  = pw[(3-d)*4 +: 4];
            exp_q.push_back({en_e, exp_seg(st, nib)});
            tag_q.push_back(tag);
        end
    endtask

    task automatic set_and_push(input logic [1:0] st, input logic [15:0] pw, input string tag);
        lock_status = st;
        passcode    = pw;
        push_frame(st, pw, tag);
    endtask

    task automatic wait_frame_start();
        do @(negedge clk); while (en_n == 4'b0111);
        do @(negedge clk); while (en_n != 4'b0111);
    endtask

    // Monitor: pops one expected entry per output change; checks dwell (R4).
    logic [10:0] prev_out = {4'b0111, 7'h7F};
    logic [3:0]  prev_en  = 4'b0111;
    int          dwell_cnt = 0;
    bit          seen_en_change = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            dwell_cnt++;
            if ({en_n, seg_n} != prev_out) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected change", {en_n, seg_n}, 0);
                end else begin
                    logic [10:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({en_n, seg_n} == e, t, {en_n, seg_n}, e);
                end
                chk(dp_n == 1'b1, "R11", dp_n, 1);
            end
            if (en_n != prev_en) begin
                if (seen_en_change) chk(dwell_cnt == DW, "R4 dwell", dwell_cnt, DW);
                seen_en_change = 1;
                dwell_cnt = 0;
            end
        end
        prev_out = {en_n, seg_n};
        prev_en  = en_n;
    end

    // Driver.
    initial begin
        rst_n       = 1'b0;
        lock_status = 2'b00;
        passcode    = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(en_n == 4'b0111, "R1 enable", en_n, 4'b0111);
        chk(seg_n == 7'h7F, "R1 segments", seg_n, 7'h7F);
        chk(dp_n == 1'b1, "R1 dp", dp_n, 1);
        push_frame(2'b00, 16'h0000, "R5");
        rst_n = 1'b1;
        @(negedge clk);
        chk(seg_n == 7'h7F, "R2 dark first edge", seg_n, 7'h7F);
        set_and_push(2'b01, 16'h0000, "R6");
        wait_frame_start();
        set_and_push(2'b10, 16'h1234, "R8");
        wait_frame_start();
        set_and_push(2'b10, 16'h5678, "R9");
        wait_frame_start();
        lock_status = 2'b10;
        passcode    = 16'h9ABC;
        repeat (DW + 3) @(negedge clk);
        set_and_push(2'b10, 16'hDEF0, "R10 mid-frame swap");
        wait_frame_start();
        set_and_push(2'b11, 16'hFFFF, "R7");
        wait_frame_start();
        lock_status = 2'b01;
        passcode    = 16'h0000;
        repeat (2 * DW) @(negedge clk);
        set_and_push(2'b10, 16'hC3A5, "R10 status swap");
        wait_frame_start();
        repeat (3 * DW + 2) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all digits seen", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule